// File: doc/BRIEF.md
# Segmented SPI Transfer Controller

This block runs a list of SPI transaction segments one after another, with no software action between them. Software first writes the segment descriptors into a small internal descriptor memory. It then enables segmented mode and starts the list by giving a segment count. The controller takes the descriptors in index order. For each one it works out the length of every phase, runs a phase sequencer through chip-select setup, command, address, dummy, data and chip-select hold, and then keeps chip select inactive for that segment's gap before it launches the next segment.

A descriptor holds a 5-bit override mask and its own lengths for every phase. Where a mask bit is clear, the segment takes the device default for that phase from the default-length inputs. The data length always comes from the descriptor. Every phase counts one clock per bit. A phase of length zero is skipped. The controller reports completion once, after the final segment. It does not add a gap after the last segment.

Top module: `segxfer_ctrl`

## Requirements
- R1: After reset, cs_n is 1, phase is 0 (idle), and busy, done, err and mode_on are all 0.
- R2: Inside a segment the phases run in the fixed order setup (code 1), command (2), address (3), dummy (4), data (5), hold (6). Each phase shows on `phase` for exactly its length in clocks, a phase of length 0 is skipped, and cs_n is 0 exactly while phase is not 0.
- R3: Override mask bit 0 selects the descriptor's setup length, bit 1 the command length, bit 2 the address length, bit 3 the dummy length and bit 4 the hold length. Where a bit is clear, that phase uses the matching default-length input. The data length always comes from the descriptor.
- R4: Between segment i and segment i+1, cs_n stays 1 for exactly gap_i + 2 clocks, where gap_i is the 32-bit gap field of segment i.
- R5: An accepted start runs descriptors 0 to seg_count-1 in order, and a count of 1 is valid. busy rises one clock after the start edge, and cs_n of the first segment falls one clock after that.
- R6: done is a single-clock pulse. It rises two clocks after the last hold clock, and busy falls in the same clock. No gap follows the last segment.
- R7: A start with segmented mode off, with seg_count equal to 0, or with seg_count greater than DEPTH sets err. Nothing runs: busy and cs_n do not move. The next accepted start clears err.
- R8: A mode write (mode_wr) takes effect only when the controller is idle and start is low in the same clock. Otherwise mode_on keeps its value.
- R9: A start pulse while busy is ignored. The running list continues unchanged, and no second list follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Request to write the segmented-mode enable |
| mode_val | input | 1 | Value to write to the mode enable |
| mode_on | output | 1 | Segmented mode currently enabled |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | IDX_W | Descriptor index to write |
| dw_mask | input | 5 | Override mask of the written descriptor |
| dw_setup | input | LEN_W | Descriptor setup length |
| dw_cmd | input | LEN_W | Descriptor command length |
| dw_addr | input | LEN_W | Descriptor address length |
| dw_dummy | input | LEN_W | Descriptor dummy length |
| dw_hold | input | LEN_W | Descriptor hold length |
| dw_data | input | LEN_W | Descriptor data length |
| dw_gap | input | GAP_W | Inactive gap after this segment, in clocks |
| def_setup | input | LEN_W | Device default setup length |
| def_cmd | input | LEN_W | Device default command length |
| def_addr | input | LEN_W | Device default address length |
| def_dummy | input | LEN_W | Device default dummy length |
| def_hold | input | LEN_W | Device default hold length |
| start | input | 1 | Start the list |
| seg_count | input | CNT_W | Number of segments in the list |
| busy | output | 1 | List in progress |
| done | output | 1 | One-clock pulse when the list completes |
| err | output | 1 | Last start was rejected |
| seg_idx | output | IDX_W | Index of the current segment |
| cs_n | output | 1 | Chip select, active low |
| phase | output | 3 | Current phase code (0 idle, 1 to 6 as in R2) |

## Verification
A wrong phase counter or a wrong skip decision shows on `phase` in the same clock: the code holds for one clock too many or too few, or a zero-length phase appears. The cycle-exact trace comparison catches both at once. A wrong override selection or a wrong gap count changes the length of a phase or of an inactive stretch, so the trace shows it within that segment or gap. A wrong list index or wrong last-segment detection shows up as an extra or missing segment, or as done arriving at the wrong clock. Rejection errors are visible on err and mode_on in the clock after the attempt.

// File: rtl/segxfer_pkg.sv
package segxfer_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_CMD   = 3'd2,
        PH_ADDR  = 3'd3,
        PH_DUMMY = 3'd4,
        PH_DATA  = 3'd5,
        PH_HOLD  = 3'd6
    } phase_e;

    localparam int NUM_OVR = 5;   // phases whose length can be overridden
    localparam int NUM_PH  = 6;   // active phases of one segment
endpackage

// File: rtl/segxfer_desc_mem.sv
module segxfer_desc_mem #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 68,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [WIDTH-1:0] rd_data_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
    end

    assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/segxfer_resolve.sv
module segxfer_resolve import segxfer_pkg::*; #(
    parameter int LEN_W = 6
) (
    input  logic [NUM_OVR-1:0]            mask_i,
    input  logic [NUM_OVR-1:0][LEN_W-1:0] own_i,
    input  logic [NUM_OVR-1:0][LEN_W-1:0] def_i,
    output logic [NUM_OVR-1:0][LEN_W-1:0] eff_o
);
    for (genvar k = 0; k < NUM_OVR; k++) begin : g_sel
        assign eff_o[k] = mask_i[k] ? own_i[k] : def_i[k];
    end
endmodule

// File: rtl/segxfer_phase_seq.sv
module segxfer_phase_seq import segxfer_pkg::*; #(
    parameter int LEN_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch_i,
    input  logic [NUM_PH-1:0][LEN_W-1:0] len_i,
    output phase_e                       phase_o,
    output logic                         fin_o
);
    typedef struct packed {
        phase_e                       ph;
        logic [LEN_W-1:0]             cnt;
        logic                         fin;
        logic [NUM_PH-1:0][LEN_W-1:0] lens;
    } seq_t;

    seq_t q, d;
    logic [2:0] nxt;

    // lowest non-empty phase at index >= from, returned as its code (index+1), 0 if none
    function automatic logic [2:0] first_nz(input logic [NUM_PH-1:0][LEN_W-1:0] l,
                                            input logic [2:0] from);
        logic [2:0] r;
        r = 3'd0;
        for (int j = NUM_PH - 1; j >= 0; j--) begin
            if (3'(j) >= from && l[j] != '0) r = 3'(j + 1);
        end
        return r;
    endfunction

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        nxt   = 3'd0;
        if (q.ph == PH_IDLE) begin
            if (launch_i) begin
                d.lens = len_i;
                nxt    = first_nz(len_i, 3'd0);
                if (nxt == 3'd0) begin
                    d.fin = 1'b1;
                end else begin
                    d.ph  = phase_e'(nxt);
                    d.cnt = len_i[nxt - 3'd1];
                end
            end
        end else if (q.cnt == LEN_W'(1)) begin
            nxt = first_nz(q.lens, q.ph);
            if (nxt == 3'd0) begin
                d.ph  = PH_IDLE;
                d.fin = 1'b1;
            end else begin
                d.ph  = phase_e'(nxt);
                d.cnt = q.lens[nxt - 3'd1];
            end
        end else begin
            d.cnt = q.cnt - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phase_o = q.ph;
    assign fin_o   = q.fin;
endmodule

// File: rtl/segxfer_ctrl.sv
module segxfer_ctrl import segxfer_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int LEN_W = 6,
    parameter int GAP_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_val,
    output logic             mode_on,
    input  logic             dw_en,
    input  logic [IDX_W-1:0] dw_idx,
    input  logic [4:0]       dw_mask,
    input  logic [LEN_W-1:0] dw_setup,
    input  logic [LEN_W-1:0] dw_cmd,
    input  logic [LEN_W-1:0] dw_addr,
    input  logic [LEN_W-1:0] dw_dummy,
    input  logic [LEN_W-1:0] dw_hold,
    input  logic [LEN_W-1:0] dw_data,
    input  logic [GAP_W-1:0] dw_gap,
    input  logic [LEN_W-1:0] def_setup,
    input  logic [LEN_W-1:0] def_cmd,
    input  logic [LEN_W-1:0] def_addr,
    input  logic [LEN_W-1:0] def_dummy,
    input  logic [LEN_W-1:0] def_hold,
    input  logic             start,
    input  logic [CNT_W-1:0] seg_count,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [IDX_W-1:0] seg_idx,
    output logic             cs_n,
    output logic [2:0]       phase
);
    typedef struct packed {
        logic [NUM_OVR-1:0] mask;
        logic [LEN_W-1:0]   setup;
        logic [LEN_W-1:0]   cmd;
        logic [LEN_W-1:0]   addr;
        logic [LEN_W-1:0]   dummy;
        logic [LEN_W-1:0]   hold;
        logic [LEN_W-1:0]   data;
        logic [GAP_W-1:0]   gap;
    } desc_t;
    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_GAP} st_e;

    typedef struct packed {
        st_e              st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic [GAP_W-1:0] gap;
        logic             done;
        logic             err;
        logic             mode;
    } ctl_t;

    ctl_t  q, d;
    desc_t wr_desc, rd_desc;
    logic [DESC_W-1:0] rd_raw;
    logic [NUM_OVR-1:0][LEN_W-1:0] own_len, def_len, eff_len;
    logic [NUM_PH-1:0][LEN_W-1:0]  seq_len;
    logic   launch, seq_fin;
    phase_e seq_ph;

    assign wr_desc = '{mask: dw_mask, setup: dw_setup, cmd: dw_cmd, addr: dw_addr,
                       dummy: dw_dummy, hold: dw_hold, data: dw_data, gap: dw_gap};

    segxfer_desc_mem #(.DEPTH(DEPTH), .WIDTH(DESC_W)) i_mem (
        .clk       (clk),
        .wr_en_i   (dw_en),
        .wr_idx_i  (dw_idx),
        .wr_data_i (wr_desc),
        .rd_idx_i  (q.idx),
        .rd_data_o (rd_raw)
    );
    assign rd_desc = desc_t'(rd_raw);

    assign own_len = {rd_desc.hold, rd_desc.dummy, rd_desc.addr, rd_desc.cmd, rd_desc.setup};
    assign def_len = {def_hold, def_dummy, def_addr, def_cmd, def_setup};

    segxfer_resolve #(.LEN_W(LEN_W)) i_res (
        .mask_i (rd_desc.mask),
        .own_i  (own_len),
        .def_i  (def_len),
        .eff_o  (eff_len)
    );

    assign seq_len = {eff_len[4], rd_desc.data, eff_len[3], eff_len[2], eff_len[1], eff_len[0]};

    segxfer_phase_seq #(.LEN_W(LEN_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .len_i    (seq_len),
        .phase_o  (seq_ph),
        .fin_o    (seq_fin)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        launch = 1'b0;
        if (mode_wr && q.st == ST_IDLE && !start) d.mode = mode_val;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!q.mode || seg_count == '0 || seg_count > CNT_W'(DEPTH)) begin
                        d.err = 1'b1;
                    end else begin
                        d.err  = 1'b0;
                        d.idx  = '0;
                        d.last = IDX_W'(seg_count - CNT_W'(1));
                        d.st   = ST_LOAD;
                    end
                end
            end
            ST_LOAD: begin
                launch = 1'b1;
                d.gap  = rd_desc.gap;
                d.st   = ST_RUN;
            end
            ST_RUN: begin
                if (seq_fin) begin
                    if (q.idx == q.last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else if (q.gap == '0) begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = ST_LOAD;
                    end else begin
                        d.st = ST_GAP;
                    end
                end
            end
            default: begin
                if (q.gap == GAP_W'(1)) begin
                    d.idx = q.idx + IDX_W'(1);
                    d.st  = ST_LOAD;
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_on = q.mode;
    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign err     = q.err;
    assign seg_idx = q.idx;
    assign phase   = seq_ph;
    assign cs_n    = (seq_ph == PH_IDLE);
endmodule

// File: rtl/segxfer_ctrl_chk.sv
module segxfer_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       cs_n,
    input logic [2:0] phase,
    input logic       mode_on
);
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n));                                   // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R6
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !busy);                                       // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_on));                                  // R8
    AST_PHASE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> (phase >= $past(phase)));        // R2
    AST_CS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);                                             // R5
endmodule

bind segxfer_ctrl segxfer_ctrl_chk i_chk (.*);

// File: tb/test_segxfer_ctrl.sv
`timescale 1ns/1ps
module test_segxfer_ctrl;
    localparam int DEPTH = 8;
    localparam int LEN_W = 6;
    localparam int GAP_W = 32;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_wr = 0, mode_val = 0, mode_on;
    logic dw_en = 0;
    logic [IDX_W-1:0] dw_idx = '0;
    logic [4:0] dw_mask = '0;
    logic [LEN_W-1:0] dw_setup = '0, dw_cmd = '0, dw_addr = '0, dw_dummy = '0, dw_hold = '0, dw_data = '0;
    logic [GAP_W-1:0] dw_gap = '0;
    logic [LEN_W-1:0] def_setup, def_cmd, def_addr, def_dummy, def_hold;
    logic start = 0;
    logic [CNT_W-1:0] seg_count = '0;
    logic busy, done, err, cs_n;
    logic [IDX_W-1:0] seg_idx;
    logic [2:0] phase;

    always #4 clk = ~clk;

    segxfer_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .GAP_W(GAP_W)) i_segxfer_ctrl (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench copy of descriptors: lengths in order setup, cmd, addr, dummy, data, hold
    logic [4:0] b_mask [DEPTH];
    int         b_len  [DEPTH][6];
    int         b_gap  [DEPTH];
    int         d_len  [5];

    logic [5:0] exp_q [$];    // {busy, done, cs_n, phase}
    bit armed = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff_len(input int s, input int p);
        int bitpos;
        if (p == 4) return b_len[s][4];
        bitpos = (p == 5) ? 4 : p;
        return b_mask[s][bitpos] ? b_len[s][p] : d_len[bitpos];
    endfunction

    task automatic wr_desc(input int s, input logic [4:0] m, input int su, input int cm,
                           input int ad, input int du, input int da, input int ho, input int g);
        b_mask[s] = m;
        b_len[s][0] = su; b_len[s][1] = cm; b_len[s][2] = ad;
        b_len[s][3] = du; b_len[s][4] = da; b_len[s][5] = ho;
        b_gap[s] = g;
        @(negedge clk);
        dw_en = 1; dw_idx = IDX_W'(s); dw_mask = m;
        dw_setup = LEN_W'(su); dw_cmd = LEN_W'(cm); dw_addr = LEN_W'(ad);
        dw_dummy = LEN_W'(du); dw_data = LEN_W'(da); dw_hold = LEN_W'(ho);
        dw_gap = GAP_W'(g);
        @(negedge clk);
        dw_en = 0;
    endtask

    // driver: push the expected trace, then start; optional disturbance mid-run (R8, R9)
    task automatic run_list(input int cnt, input bit disturb);
        for (int s = 0; s < cnt; s++) begin
            exp_q.push_back({1'b1, 1'b0, 1'b1, 3'd0});              // load clock
            for (int p = 0; p < 6; p++)
                for (int k = 0; k < eff_len(s, p); k++)
                    exp_q.push_back({1'b1, 1'b0, 1'b0, 3'(p + 1)}); // R2 R3
            exp_q.push_back({1'b1, 1'b0, 1'b1, 3'd0});              // end clock
            if (s != cnt - 1)
                for (int k = 0; k < b_gap[s]; k++)
                    exp_q.push_back({1'b1, 1'b0, 1'b1, 3'd0});      // R4 gap
        end
        exp_q.push_back({1'b0, 1'b1, 1'b1, 3'd0});                  // R6 done
        exp_q.push_back({1'b0, 1'b0, 1'b1, 3'd0});                  // R6 single pulse, R9 no rerun
        exp_q.push_back({1'b0, 1'b0, 1'b1, 3'd0});
        @(negedge clk);
        seg_count = CNT_W'(cnt); start = 1;
        @(posedge clk); #1;
        start = 0;
        armed = 1;
        if (disturb) begin
            repeat (3) @(negedge clk);
            start = 1; mode_wr = 1; mode_val = 0;                   // R9, R8
            @(posedge clk); #1;
            start = 0; mode_wr = 0;
        end
        wait (exp_q.size() == 0);
        armed = 0;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        logic [5:0] e, a;
        forever begin
            @(negedge clk);
            if (armed && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                a = {busy, done, cs_n, phase};
                chk(a == e, "R2/R4/R5/R6 trace", int'(a), int'(e));
            end
        end
    end

    initial begin
        #(8 * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        d_len = '{2, 3, 4, 1, 2};
        def_setup = 6'd2; def_cmd = 6'd3; def_addr = 6'd4; def_dummy = 6'd1; def_hold = 6'd2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({cs_n, phase, busy, done, err, mode_on} == 8'b1_000_0000, "R1 reset",
            int'({cs_n, phase, busy, done, err, mode_on}), 128);
        rst_n = 1;
        @(negedge clk);

        // R7 start with mode off
        seg_count = 1; start = 1;
        @(negedge clk); start = 0;
        chk(err == 1, "R7 mode off err", err, 1);
        chk(busy == 0 && cs_n == 1, "R7 mode off idle", busy, 0);

        // R8 mode write refused when start same clock
        mode_wr = 1; mode_val = 1; start = 1; seg_count = 0;
        @(negedge clk); mode_wr = 0; start = 0;
        chk(mode_on == 0, "R8 refused with start", mode_on, 0);

        // R8 accepted write
        mode_wr = 1; mode_val = 1;
        @(negedge clk); mode_wr = 0;
        chk(mode_on == 1, "R8 enable", mode_on, 1);

        // R7 count zero and count too large
        seg_count = 0; start = 1;
        @(negedge clk); start = 0;
        chk(err == 1 && busy == 0, "R7 count zero", int'({err, busy}), 2);
        seg_count = CNT_W'(DEPTH + 1); start = 1;
        @(negedge clk); start = 0;
        chk(err == 1 && busy == 0 && cs_n == 1, "R7 count over", int'({err, busy}), 2);

        // R5 R3 one-segment list, all defaults
        wr_desc(0, 5'b00000, 9, 9, 9, 9, 3, 9, 5);
        run_list(1, 0);
        chk(err == 0, "R7 err cleared by good start", err, 0);

        // R3 R4 R5 mixed overrides, zero lengths, gaps 0 and 3
        wr_desc(0, 5'b11111, 1, 0, 2, 0, 4, 1, 3);
        wr_desc(1, 5'b01010, 0, 5, 0, 2, 1, 0, 0);
        wr_desc(2, 5'b10100, 7, 7, 0, 7, 2, 3, 6);
        run_list(3, 0);

        // R8 R9 disturb during a longer list
        wr_desc(3, 5'b00001, 4, 0, 0, 0, 8, 0, 2);
        run_list(4, 1);
        chk(mode_on == 1, "R8 refused while busy", mode_on, 1);
        chk(busy == 0 && seg_idx == IDX_W'(3), "R9 no rerun", int'(seg_idx), 3);

        // R8 disable when idle, then R7 start rejected again
        mode_wr = 1; mode_val = 0;
        @(negedge clk); mode_wr = 0;
        chk(mode_on == 0, "R8 disable", mode_on, 0);
        seg_count = 2; start = 1;
        @(negedge clk); start = 0;
        chk(err == 1 && cs_n == 1, "R7 disabled start", err, 1);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end
endmodule